// File: doc/BRIEF.md
# Generation-Bit Completion Ring Writer

This block is the producer side of a completion ring in which each slot carries its own validity mark. Each completion event arrives over a valid/ready handshake. An event carries a 16-bit identifier, a small status field and an end-of-packet flag. The identifier is a transmit completion tag or a receive buffer id. The block writes each event into the next slot of an internal power-of-two ring. In that same single write it stamps the slot with a generation bit. The bit is inverted from what a reader currently expects, so a reader sees a fresh entry through that bit alone, without a producer index register.

After reset the block sweeps the whole ring once. The sweep sets every slot to a zero payload with generation 0, which is the reader's starting expectation, and the handshake stays closed for the whole sweep. The first pass then writes generation 1. Every wrap of the write index inverts the bit written on the next pass. One received packet may fill several consecutive slots, and only the last of them carries the end-of-packet flag.

A reader walks the ring through a read port with one cycle of latency. It treats a slot as new when the slot's generation bit differs from its own expected value, and it inverts that expectation whenever it wraps. The reader returns its consumed count on `cons_idx`. The block does not throttle on that count. Keeping the producer within one ring of the consumer is the host's duty, and a bound checker watches for it.

Top module: `cq_gen_writer`

## Requirements
- R1: From reset, `in_ready` stays low for exactly DEPTH rising edges after reset is released, and then stays high. After this sweep every slot reads as 32'h0000_0000 (generation bit 0, zero payload).
- R2: Each accepted event is written to slot `prod_idx mod DEPTH`. Events land in consecutive slots in acceptance order, with their tag, status and end-of-packet flag unchanged.
- R3: The gap `prod_idx - cons_idx` (modulo 2*DEPTH) never exceeds DEPTH. No event is accepted while the gap equals DEPTH.
- R4: The generation bit written for the n-th accepted event since reset (n counted from 0) is 1 when floor(n/DEPTH) is even and 0 when it is odd, so it inverts on every wrap.
- R5: A slot is a 32-bit little-endian word. Byte 0 (bits 7:0) is the tag's low byte and byte 1 (bits 15:8) is its high byte. Byte 2 bits 3:0 (word bits 19:16) hold the status, and the rest of byte 2 is zero. Byte 3 bit 6 (word bit 30) is end-of-packet, byte 3 bit 7 (word bit 31) is the generation bit, and byte 3 bits 5:0 are zero.
- R6: At most one event is accepted per cycle, on a rising edge with both `in_valid` and `in_ready` high. `prod_idx` (DEPTH*2 modulo counter) advances by exactly one per accepted event. `in_valid` while `in_ready` is low has no effect.
- R7: `rd_data` shows the slot addressed by `rd_addr` one rising edge after the address is applied, and holds its value until then.
- R8: A slot the producer has not yet written in the reader's current pass carries a generation bit equal to the reader's expectation. A reader following the rule therefore stops exactly at the producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Completion event offered |
| in_ready | output | 1 | Writer can take an event (registered) |
| in_tag | input | 16 | Completion tag or buffer id |
| in_status | input | 4 | Status bits of the event |
| in_last | input | 1 | Final entry of a packet |
| cons_idx | input | log2(DEPTH)+1 | Reader's consumed count, modulo 2*DEPTH |
| prod_idx | output | log2(DEPTH)+1 | Producer's written count, modulo 2*DEPTH |
| rd_addr | input | log2(DEPTH) | Reader slot address |
| rd_data | output | 32 | Slot contents, one cycle after the address |

## Verification
The bench covers these corner cases:

- **Events offered during the reset sweep.** A writer that accepted them would advance `prod_idx` or leave a slot with a generation bit set before the reader's first pass.
- **Wraps.** Random bursts run the ring through many wraps, and one directed burst fills it to exactly DEPTH outstanding entries. A writer that forgot the inversion, or inverted one slot early or late, would make the reader model either miss entries or take stale slots as new.
- **Stop point.** After each drain, the reader probes the slot just past the producer. A wrong sweep or generation value would show up there as a phantom entry.
- **Packing and read timing.** Multi-entry packets and a fixed byte pattern catch fields packed in the wrong order. A read port that answers early or late returns the wrong slot.

// File: rtl/cqw_pkg.sv
package cqw_pkg;
  parameter int TAG_W  = 16;
  parameter int STAT_W = 4;
  parameter int DESC_W = 32;
  localparam int RSVD_W = DESC_W - TAG_W - STAT_W - 2;

  // Slot layout, least significant byte first in memory order.
  typedef struct packed {
    logic              gen;
    logic              last;
    logic [RSVD_W-1:0] rsvd;
    logic [STAT_W-1:0] status;
    logic [TAG_W-1:0]  tag;
  } cq_desc_t;
endpackage

// File: rtl/cq_ptr.sv
module cq_ptr #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  output logic             init_busy,
  output logic             ready,
  output logic             gen_next,
  output logic [IDX_W-1:0] slot,
  output logic [IDX_W:0]   prod
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] SLOT_ONE  = IDX_W'(1);
  localparam logic [IDX_W:0]   PROD_ONE  = (IDX_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      prod      <= '0;
      init_busy <= 1'b1;
      ready     <= 1'b0;
      gen_next  <= 1'b1;
    end else if (init_busy) begin
      slot <= slot + SLOT_ONE;
      if (slot == LAST_SLOT) begin
        init_busy <= 1'b0;
        ready     <= 1'b1;
      end
    end else if (push) begin
      slot <= slot + SLOT_ONE;
      prod <= prod + PROD_ONE;
      if (slot == LAST_SLOT) gen_next <= ~gen_next;
    end
  end
endmodule

// File: rtl/cq_pack.sv
module cq_pack
  import cqw_pkg::*;
(
  input  logic              init_busy,
  input  logic              gen_next,
  input  logic [TAG_W-1:0]  tag,
  input  logic [STAT_W-1:0] status,
  input  logic              last,
  output cq_desc_t          word
);
  always_comb begin
    word = '0;
    if (init_busy) begin
      // Sweep value: the reader's starting expectation.
      word.gen = ~gen_next;
    end else begin
      word.tag    = tag;
      word.status = status;
      word.last   = last;
      word.gen    = gen_next;
    end
  end
endmodule

// File: rtl/cq_ram.sv
module cq_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cq_gen_writer.sv
module cq_gen_writer
  import cqw_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [STAT_W-1:0] in_status,
  input  logic              in_last,
  input  logic [IDX_W:0]    cons_idx,
  output logic [IDX_W:0]    prod_idx,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DESC_W-1:0] rd_data
);
  logic             init_busy;
  logic             gen_next;
  logic             push;
  logic             wr_en;
  logic [IDX_W-1:0] slot;
  cq_desc_t         wr_word;

  assign push  = in_valid & in_ready;
  assign wr_en = init_busy | push;

  cq_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .init_busy (init_busy),
    .ready     (in_ready),
    .gen_next  (gen_next),
    .slot      (slot),
    .prod      (prod_idx)
  );

  cq_pack u_pack (
    .init_busy (init_busy),
    .gen_next  (gen_next),
    .tag       (in_tag),
    .status    (in_status),
    .last      (in_last),
    .word      (wr_word)
  );

  cq_ram #(.AW(IDX_W), .DW(DESC_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (slot),
    .wdata (wr_word),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/cq_gen_writer_chk.sv
module cq_gen_writer_chk
  import cqw_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              init_busy,
  input logic              wr_en,
  input logic [DESC_W-1:0] wr_word,
  input logic [IDX_W:0]    prod_idx,
  input logic [IDX_W:0]    cons_idx
);
  localparam logic [IDX_W:0] FULL    = (IDX_W+1)'(DEPTH);
  localparam logic [IDX_W:0] IDX_ONE = (IDX_W+1)'(1);

  logic [IDX_W:0] gap;
  logic [IDX_W:0] prod_step;
  logic           accept;

  assign gap       = prod_idx - cons_idx;
  assign prod_step = prod_idx + IDX_ONE;
  assign accept    = in_valid & in_ready;

  // R3: producer stays within one ring of the consumer.
  p_no_overrun_r3: assert property (@(posedge clk) disable iff (rst)
    gap <= FULL);
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (rst)
    accept |-> gap < FULL);

  // R1: closed handshake and zero-generation writes during the sweep.
  p_sweep_closed_r1: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !in_ready && wr_en && !wr_word[DESC_W-1]);
  p_ready_held_r1: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

  // R6: one step per accepted event, none otherwise.
  p_one_step_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> prod_idx == $past(prod_step));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(prod_idx));

  // R4: written generation follows the pass parity of the count.
  p_gen_parity_r4: assert property (@(posedge clk) disable iff (rst)
    accept |-> wr_word[DESC_W-1] == ~prod_idx[IDX_W]);
endmodule

bind cq_gen_writer cq_gen_writer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .init_busy (init_busy),
  .wr_en     (wr_en),
  .wr_word   (wr_word),
  .prod_idx  (prod_idx),
  .cons_idx  (cons_idx)
);

// File: tb/cq_gen_writer_bench.sv
module cq_gen_writer_bench;
  localparam int DEPTH = 16;
  localparam int IW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   in_tag = '0;
  logic [3:0]    in_status = '0;
  logic          in_last = 1'b0;
  logic [IW:0]   cons_idx = '0;
  logic [IW:0]   prod_idx;
  logic [IW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] shadow [DEPTH];
  int wcount  = 0;
  int rcount  = 0;
  int pkt_left = 0;
  bit exp_cur = 1'b0;

  always #2 clk = ~clk;

  cq_gen_writer #(.DEPTH(DEPTH)) u_cq_gen_writer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_status(in_status), .in_last(in_last),
    .cons_idx(cons_idx), .prod_idx(prod_idx),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(bit ok, string req, string what,
                       logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] make_word(logic [15:0] t, logic [3:0] s,
                                            logic l, logic g);
    return {g, l, 6'b0, 4'b0, s, t};
  endfunction

  function automatic logic gen_for(int n);
    return ((n / DEPTH) % 2) == 0;
  endfunction

  task automatic read_slot(int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = IW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic push_one(logic [15:0] t, logic [3:0] s, logic l);
    in_valid  = 1'b1;
    in_tag    = t;
    in_status = s;
    in_last   = l;
    shadow[wcount % DEPTH] = make_word(t, s, l, gen_for(wcount));
    @(negedge clk);
    wcount++;
    check(prod_idx == (IW+1)'(wcount % (2*DEPTH)), "R6", "prod_idx step",
          32'(prod_idx), 32'(wcount % (2*DEPTH)));
  endtask

  task automatic push_burst(int n, bit gaps);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic l;
      if (gaps && ($urandom_range(0, 2) == 0)) begin
        in_valid = 1'b0;
        repeat ($urandom_range(1, 3)) @(negedge clk);
      end
      if (pkt_left == 0) pkt_left = $urandom_range(1, 3);
      l = (pkt_left == 1);
      pkt_left--;
      push_one(16'($urandom), 4'($urandom), l);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    logic [31:0] d;
    for (int k = 0; k <= 2*DEPTH + 1; k++) begin
      read_slot(rcount % DEPTH, d);
      if (rcount < wcount) begin
        check(d[31] != exp_cur, "R8", "pending slot seen as new", 32'(d[31]), 32'(!exp_cur));
        check(d[31] == gen_for(rcount), "R4", "generation of entry", 32'(d[31]), 32'(gen_for(rcount)));
        check(d == shadow[rcount % DEPTH], "R2", "slot contents", d, shadow[rcount % DEPTH]);
        rcount++;
        cons_idx = (IW+1)'(rcount % (2*DEPTH));
        if (rcount % DEPTH == 0) exp_cur = ~exp_cur;
      end else begin
        check(d[31] == exp_cur, "R8", "slot past producer not new", 32'(d[31]), 32'(exp_cur));
        break;
      end
    end
  endtask

  initial begin : main
    logic [31:0] d;
    logic [31:0] d0;
    int edges;
    void'($urandom(32'd4242));

    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R1", "ready in reset", 32'(in_ready), 32'h0);
    check(prod_idx == '0, "R6", "prod_idx in reset", 32'(prod_idx), 32'h0);

    // Release reset with an event already offered during the sweep.
    rst = 1'b0;
    in_valid = 1'b1;
    in_tag = 16'hFFFF;
    in_status = 4'hF;
    in_last = 1'b1;
    edges = 0;
    for (int k = 0; k < 4*DEPTH; k++) begin
      @(negedge clk);
      edges++;
      if (in_ready) begin
        in_valid = 1'b0;
        break;
      end
    end
    check(edges == DEPTH, "R1", "sweep length in edges", 32'(edges), 32'(DEPTH));
    check(prod_idx == '0, "R6", "valid ignored during sweep", 32'(prod_idx), 32'h0);

    for (int a = 0; a < DEPTH; a++) begin
      read_slot(a, d);
      check(d == 32'h0, "R1", "swept slot value", d, 32'h0);
    end
    check(in_ready == 1'b1, "R1", "ready held after sweep", 32'(in_ready), 32'h1);

    // Byte layout with a fixed pattern.
    @(negedge clk);
    push_one(16'hA55A, 4'h9, 1'b1);
    in_valid = 1'b0;
    read_slot(0, d);
    check(d[7:0] == 8'h5A, "R5", "byte 0", 32'(d[7:0]), 32'h5A);
    check(d[15:8] == 8'hA5, "R5", "byte 1", 32'(d[15:8]), 32'hA5);
    check(d[23:16] == 8'h09, "R5", "byte 2", 32'(d[23:16]), 32'h09);
    check(d[31:24] == 8'hC0, "R5", "byte 3", 32'(d[31:24]), 32'hC0);

    // Read latency: old value holds until the edge, then the new slot.
    d0 = d;
    @(negedge clk);
    rd_addr = IW'(1);
    #1;
    check(rd_data == d0, "R7", "data holds before edge", rd_data, d0);
    @(negedge clk);
    check(rd_data == 32'h0, "R7", "new slot after one edge", rd_data, 32'h0);

    drain();

    // Directed: fill to exactly one ring outstanding, back to back.
    push_burst(DEPTH, 1'b0);
    check(32'(prod_idx - cons_idx) == 32'(DEPTH), "R3", "gap at full ring",
          32'(prod_idx - cons_idx), 32'(DEPTH));
    drain();

    // Random bursts across many wraps.
    for (int r = 0; r < 40; r++) begin
      push_burst($urandom_range(1, DEPTH), 1'b1);
      check(wcount - rcount <= DEPTH, "R3", "gap bound", 32'(wcount - rcount), 32'(DEPTH));
      drain();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule